// File: doc/BRIEF.md
# Secure boot flow controller

This controller runs the fixed boot sequence that follows a passed self-test. It waits in idle until the self-test sequencer reports a pass. It then optionally recovers a stored firmware key by handing it to an external AES-128 (ECB) engine. Next it has an external signature engine check the key database (RSA-PSS, 4096-bit key, SHA-384). Only after that check succeeds does it ask the memory loader to bring in the next-stage image. It then requests a signature check of that image. If the configuration asks for it, the controller has the cipher engine de-obfuscate the image with the recovered key. Finally it reports completion and stops.

Every external engine is driven through a one-cycle start pulse and a done strobe. The signature engine also returns a pass/fail bit. No operator input is taken while the sequence runs. A service-indicator bit reports whether the step in progress is an approved one. A failed signature check ends the sequence in a sticky fail state. On entry to either end state, the key register is wiped. Running the sequence again requires a reset.

Top module: `boot_seq_ctrl`

## Requirements
- R1: After reset the step code is 0 (idle) and all start pulses, flags and the key word are 0. Engine strobes are ignored, and the block stays idle until `selftest_pass` is 1 at a clock edge.
- R2: When `need_key_deob` is 1 at start, the block enters step 1. It pulses `cipher_start` with `cipher_sel`=0, and `key_word` shows `raw_key`. When `cipher_done` arrives, `cipher_result` replaces the key word.
- R3: Step 2 verifies the key database: `sig_start` pulses with `sig_sel`=0. If `need_key_deob` is 0, step 2 directly follows idle. A done with `sig_ok`=0 moves the block to step 7 (fail).
- R4: The image load (step 3, `load_start` pulse) is entered only from a successful database check.
- R5: When `load_done` arrives, step 4 verifies the image: `sig_start` pulses with `sig_sel`=1. A done with `sig_ok`=0 moves to step 7, and no de-obfuscation of the image follows.
- R6: After a passed image check, when `need_img_deob` is 1, step 5 pulses `cipher_start` with `cipher_sel`=1 while `key_word` holds the recovered key. Its `cipher_done` leads to step 6 (done). When `need_img_deob` is 0, step 6 follows the image check directly.
- R7: `svc_ind` is 1 throughout steps 2 and 4 and 0 throughout steps 1 and 5.
- R8: Steps 6 and 7 are terminal. `done_flag` or `fail_flag` stays 1, and all inputs, including `selftest_pass`, are ignored until reset.
- R9: `key_word` is 0 from the first cycle of step 6 or step 7.
- R10: Step codes: 0 idle, 1 key de-obfuscate, 2 database verify, 3 load, 4 image verify, 5 image de-obfuscate, 6 done, 7 fail.
- R11: Each start pulse is high for exactly the first cycle of its step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| selftest_pass | input | 1 | Self-test sequencer reports pass |
| need_key_deob | input | 1 | Key de-obfuscation required |
| need_img_deob | input | 1 | Image de-obfuscation required |
| raw_key | input | KEY_W | Stored (obfuscated) firmware key, fetched at start |
| cipher_start | output | 1 | Cipher engine start pulse |
| cipher_sel | output | 1 | 0 = key job, 1 = image job |
| cipher_done | input | 1 | Cipher engine finished |
| cipher_result | input | KEY_W | Recovered key from the cipher engine |
| sig_start | output | 1 | Signature engine start pulse |
| sig_sel | output | 1 | 0 = key database, 1 = image |
| sig_done | input | 1 | Signature engine finished |
| sig_ok | input | 1 | Signature verified |
| load_start | output | 1 | Image loader start pulse |
| load_done | input | 1 | Image loaded |
| key_word | output | KEY_W | Key register contents |
| step_code | output | 3 | Current step (R10) |
| svc_ind | output | 1 | Service indicator: 1 approved step |
| done_flag | output | 1 | Sequence completed |
| fail_flag | output | 1 | Sequence aborted on a signature failure |

## Verification
The state change and the matching start pulse come from the same clock edge. A start pulse is therefore due one edge after the accepting `selftest_pass` or done strobe, and `key_word` and `svc_ind` settle on that same edge. The bench drives strobes on the falling edge, advances one rising edge, and samples on the next falling edge. Each new step is checked there, and the following sample confirms that the pulse has dropped. The bench sweeps both configuration bits against three outcomes (no failure, database failure, image failure) with varied engine latency. It predicts every step, selector and key value from that configuration alone.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE     = 3'd0,
    S_KEY_DEOB = 3'd1,
    S_DB_VER   = 3'd2,
    S_LOAD     = 3'd3,
    S_IMG_VER  = 3'd4,
    S_IMG_DEOB = 3'd5,
    S_DONE     = 3'd6,
    S_FAIL     = 3'd7
  } step_e;

  function automatic logic is_verify(step_e s);
    return (s == S_DB_VER) || (s == S_IMG_VER);
  endfunction

  function automatic logic is_deob(step_e s);
    return (s == S_KEY_DEOB) || (s == S_IMG_DEOB);
  endfunction

  function automatic logic is_end(step_e s);
    return (s == S_DONE) || (s == S_FAIL);
  endfunction

  function automatic step_e first_step(logic need_key);
    return need_key ? S_KEY_DEOB : S_DB_VER;
  endfunction

  function automatic step_e after_image(logic ok, logic need_img);
    if (!ok) return S_FAIL;
    return need_img ? S_IMG_DEOB : S_DONE;
  endfunction
endpackage

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
  import boot_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  selftest_pass,
  input  logic  need_key_deob,
  input  logic  need_img_deob,
  input  logic  cipher_done,
  input  logic  sig_done,
  input  logic  sig_ok,
  input  logic  load_done,
  output step_e step,
  output logic  cipher_start,
  output logic  sig_start,
  output logic  load_start,
  output logic  ev_boot_go,
  output logic  ev_key_back,
  output logic  ev_enter_ver,
  output logic  ev_enter_deob,
  output logic  ev_enter_end
);
  step_e nxt;
  logic  entering;

  always_comb begin
    nxt = step;
    unique case (step)
      S_IDLE:     if (selftest_pass) nxt = first_step(need_key_deob);
      S_KEY_DEOB: if (cipher_done)   nxt = S_DB_VER;
      S_DB_VER:   if (sig_done)      nxt = sig_ok ? S_LOAD : S_FAIL;
      S_LOAD:     if (load_done)     nxt = S_IMG_VER;
      S_IMG_VER:  if (sig_done)      nxt = after_image(sig_ok, need_img_deob);
      S_IMG_DEOB: if (cipher_done)   nxt = S_DONE;
      default:                       nxt = step;
    endcase
  end

  assign entering      = (nxt != step);
  assign ev_boot_go    = entering && (step == S_IDLE);
  assign ev_key_back   = entering && (step == S_KEY_DEOB);
  assign ev_enter_ver  = entering && is_verify(nxt);
  assign ev_enter_deob = entering && is_deob(nxt);
  assign ev_enter_end  = entering && is_end(nxt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step         <= S_IDLE;
      cipher_start <= 1'b0;
      sig_start    <= 1'b0;
      load_start   <= 1'b0;
    end else begin
      step         <= nxt;
      cipher_start <= ev_enter_deob;
      sig_start    <= ev_enter_ver;
      load_start   <= entering && (nxt == S_LOAD);
    end
  end

  assert_idle_wait_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (step == S_IDLE && !selftest_pass) |=> (step == S_IDLE));
  assert_load_after_db_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step == S_LOAD && $past(step) != S_LOAD) |-> ($past(step) == S_DB_VER && $past(sig_ok)));
  assert_deob_after_ver_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step == S_IMG_DEOB && $past(step) != S_IMG_DEOB) |-> ($past(step) == S_IMG_VER && $past(sig_ok)));
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step == S_DONE) |=> (step == S_DONE));
  assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step == S_FAIL) |=> (step == S_FAIL));
  assert_sig_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sig_start |=> !sig_start);
  assert_cipher_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cipher_start |-> is_deob(step));
  assert_one_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cipher_start, sig_start, load_start}));
endmodule

// File: rtl/boot_seq_keyreg.sv
module boot_seq_keyreg #(
  parameter int KEY_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_raw,
  input  logic             take_result,
  input  logic             wipe,
  input  logic [KEY_W-1:0] raw_key,
  input  logic [KEY_W-1:0] result,
  output logic [KEY_W-1:0] key_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)           key_q <= '0;
    else if (wipe)        key_q <= '0;
    else if (take_result) key_q <= result;
    else if (take_raw)    key_q <= raw_key;
  end

  assert_wipe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (key_q == '0));
  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_result && !wipe) |=> (key_q == $past(result)));
endmodule

// File: rtl/boot_seq_ind.sv
module boot_seq_ind (
  input  logic clk,
  input  logic rst_n,
  input  logic set_approved,
  input  logic set_unapproved,
  output logic ind_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)              ind_q <= 1'b0;
    else if (set_approved)   ind_q <= 1'b1;
    else if (set_unapproved) ind_q <= 1'b0;
  end

  assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_approved && set_unapproved));
endmodule

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
  import boot_seq_pkg::*;
#(
  parameter int KEY_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             selftest_pass,
  input  logic             need_key_deob,
  input  logic             need_img_deob,
  input  logic [KEY_W-1:0] raw_key,
  output logic             cipher_start,
  output logic             cipher_sel,
  input  logic             cipher_done,
  input  logic [KEY_W-1:0] cipher_result,
  output logic             sig_start,
  output logic             sig_sel,
  input  logic             sig_done,
  input  logic             sig_ok,
  output logic             load_start,
  input  logic             load_done,
  output logic [KEY_W-1:0] key_word,
  output logic [2:0]       step_code,
  output logic             svc_ind,
  output logic             done_flag,
  output logic             fail_flag
);
  step_e step;
  logic  ev_boot_go, ev_key_back, ev_enter_ver, ev_enter_deob, ev_enter_end;

  boot_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .selftest_pass(selftest_pass),
    .need_key_deob(need_key_deob), .need_img_deob(need_img_deob),
    .cipher_done(cipher_done), .sig_done(sig_done), .sig_ok(sig_ok),
    .load_done(load_done), .step(step),
    .cipher_start(cipher_start), .sig_start(sig_start), .load_start(load_start),
    .ev_boot_go(ev_boot_go), .ev_key_back(ev_key_back),
    .ev_enter_ver(ev_enter_ver), .ev_enter_deob(ev_enter_deob),
    .ev_enter_end(ev_enter_end)
  );

  boot_seq_keyreg #(.KEY_W(KEY_W)) u_key (
    .clk(clk), .rst_n(rst_n), .take_raw(ev_boot_go), .take_result(ev_key_back),
    .wipe(ev_enter_end), .raw_key(raw_key), .result(cipher_result), .key_q(key_word)
  );

  boot_seq_ind u_ind (
    .clk(clk), .rst_n(rst_n), .set_approved(ev_enter_ver),
    .set_unapproved(ev_enter_deob), .ind_q(svc_ind)
  );

  assign step_code  = step;
  assign cipher_sel = (step == S_IMG_DEOB);
  assign sig_sel    = (step == S_IMG_VER);
  assign done_flag  = (step == S_DONE);
  assign fail_flag  = (step == S_FAIL);

  assert_ind_ver_R7: assert property (@(posedge clk) disable iff (!rst_n)
    is_verify(step) |-> svc_ind);
  assert_ind_deob_R7: assert property (@(posedge clk) disable iff (!rst_n)
    is_deob(step) |-> !svc_ind);
  assert_key_wiped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    is_end(step) |-> (key_word == '0));
  assert_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_flag && fail_flag));
endmodule

// File: tb/test_boot_seq_ctrl.sv
module test_boot_seq_ctrl;
  localparam int KW = 128;
  localparam logic [KW-1:0] MASK = {4{32'h5A3C_96E1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic selftest_pass = 0, need_key_deob = 0, need_img_deob = 0;
  logic [KW-1:0] raw_key = '0, cipher_result = '0;
  logic cipher_done = 0, sig_done = 0, sig_ok = 0, load_done = 0;
  logic cipher_start, cipher_sel, sig_start, sig_sel, load_start;
  logic [KW-1:0] key_word;
  logic [2:0] step_code;
  logic svc_ind, done_flag, fail_flag;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  boot_seq_ctrl #(.KEY_W(KW)) i_boot_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .selftest_pass(selftest_pass),
    .need_key_deob(need_key_deob), .need_img_deob(need_img_deob), .raw_key(raw_key),
    .cipher_start(cipher_start), .cipher_sel(cipher_sel), .cipher_done(cipher_done),
    .cipher_result(cipher_result), .sig_start(sig_start), .sig_sel(sig_sel),
    .sig_done(sig_done), .sig_ok(sig_ok), .load_start(load_start), .load_done(load_done),
    .key_word(key_word), .step_code(step_code), .svc_ind(svc_ind),
    .done_flag(done_flag), .fail_flag(fail_flag)
  );

  task automatic chk(input string req, input logic [KW-1:0] act, input logic [KW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // step entry: code, start pulses (cipher, sig, load), selectors, indicator (-1 skips)
  task automatic at_step(input string req, input int code, input bit cs, input bit ss,
                         input bit ls, input bit csel, input bit ssel, input int ind);
    chk({req, " step_code"}, KW'(step_code), KW'(code));
    chk({req, " cipher_start"}, KW'(cipher_start), KW'(cs));
    chk({req, " sig_start"}, KW'(sig_start), KW'(ss));
    chk({req, " load_start"}, KW'(load_start), KW'(ls));
    chk({req, " cipher_sel"}, KW'(cipher_sel), KW'(csel));
    chk({req, " sig_sel"}, KW'(sig_sel), KW'(ssel));
    if (ind >= 0) chk({req, " svc_ind"}, KW'(svc_ind), KW'(ind));
  endtask

  task automatic hold_wait(input int lat, input int code);
    tick();
    chk("R11 pulse dropped", KW'({cipher_start, sig_start, load_start}), '0);
    for (int i = 1; i < lat; i++) begin
      tick();
      chk("R11 step held", KW'(step_code), KW'(code));
    end
  endtask

  task automatic check_end(input bit ok);
    at_step(ok ? "R8 done" : "R3/R5 fail", ok ? 6 : 7, 0, 0, 0, 0, 0, -1);
    chk("R8 done_flag", KW'(done_flag), KW'(ok));
    chk("R8 fail_flag", KW'(fail_flag), KW'(!ok));
    chk("R9 key wiped", key_word, '0);
    sig_done = 1; sig_ok = 1; cipher_done = 1; load_done = 1;
    repeat (3) tick();
    sig_done = 0; cipher_done = 0; load_done = 0;
    tick();
    chk("R8 terminal stays", KW'(step_code), KW'(ok ? 6 : 7));
    chk("R8 no start after end", KW'({cipher_start, sig_start, load_start}), '0);
    chk("R9 key stays zero", key_word, '0);
  endtask

  // failpt: 0 none, 1 database check fails, 2 image check fails
  task automatic run(input bit nk, input bit ni, input int failpt, input int idx);
    logic [KW-1:0] rk, recovered;
    int lat;
    lat = 1 + (idx % 3);
    rk = {4{32'h1000_0001 * (idx + 3)}};
    recovered = nk ? (rk ^ MASK) : rk;
    rst_n = 0; selftest_pass = 0; need_key_deob = nk; need_img_deob = ni; raw_key = rk;
    repeat (2) tick();
    rst_n = 1;
    tick();
    at_step("R1 reset", 0, 0, 0, 0, 0, 0, 0);
    chk("R1 flags", KW'({done_flag, fail_flag}), '0);
    chk("R1 key zero", key_word, '0);
    sig_done = 1; sig_ok = 1; cipher_done = 1; load_done = 1;
    tick();
    sig_done = 0; cipher_done = 0; load_done = 0;
    tick();
    chk("R1 idle ignores strobes", KW'(step_code), 0);
    selftest_pass = 1;
    tick();
    if (nk) begin
      at_step("R2 key deob", 1, 1, 0, 0, 0, 0, 0);
      chk("R2 key_word raw", key_word, rk);
      hold_wait(lat, 1);
      cipher_done = 1; cipher_result = rk ^ MASK;
      tick();
      cipher_done = 0; cipher_result = '0;
    end
    at_step("R3 db verify", 2, 0, 1, 0, 0, 0, 1);
    chk("R2 key after step", key_word, recovered);
    hold_wait(lat, 2);
    sig_done = 1; sig_ok = (failpt != 1);
    tick();
    sig_done = 0; sig_ok = 0;
    if (failpt == 1) begin check_end(0); return; end
    at_step("R4 load", 3, 0, 0, 1, 0, 0, 1);
    hold_wait(lat, 3);
    load_done = 1;
    tick();
    load_done = 0;
    at_step("R5 img verify", 4, 0, 1, 0, 0, 1, 1);
    hold_wait(lat, 4);
    sig_done = 1; sig_ok = (failpt != 2);
    tick();
    sig_done = 0; sig_ok = 0;
    if (failpt == 2) begin check_end(0); return; end
    if (ni) begin
      at_step("R6 img deob", 5, 1, 0, 0, 1, 0, 0);
      chk("R6 key for image", key_word, recovered);
      hold_wait(lat, 5);
      cipher_done = 1;
      tick();
      cipher_done = 0;
    end
    check_end(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int idx;
    idx = 0;
    @(negedge clk);
    for (int k = 0; k < 2; k++)
      for (int m = 0; m < 2; m++)
        for (int f = 0; f < 3; f++) begin
          run(k[0], m[0], f, idx);
          idx++;
        end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule